// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block derives a panel pixel rate from a reference clock. It does not generate a second clock domain. It runs on the reference clock and produces two outputs. The first is a one-cycle clock-enable strobe that marks the start of every output period. The second is a phase level that traces the shape of the divided clock.

The division ratio comes from two narrow divisor fields, a low one and a high one, which are joined into a single programmed value. The effective divisor is that value plus two. A separate bypass input selects divide-by-one. In that case the strobe fires on every reference cycle and the contents of the divisor fields are ignored.

A new divisor is latched only where one output period ends and the next begins, so a period is never cut short. Downstream pixel logic qualifies its registers with the strobe, and the phase output can drive a pad as the panel clock.

Top module: `pixclk_div`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both `pix_ce` and `pix_phase` are 0 after that edge and the period counter returns to zero.
- R2: On the first rising edge with `rst_n` high after reset, a new output period begins: `pix_ce` and `pix_phase` are 1 after that edge.
- R3: With `bypass` low, `pix_ce` is 1 for exactly one reference cycle in every D cycles, where D = programmed value + 2.
- R4: The programmed value is `{div_hi, div_lo}`, with `div_lo` supplying the least significant bits. For example, `div_hi`=1 and `div_lo`=0 give a programmed value of 32 and D=34.
- R5: With `bypass` high, D=1 whatever the divisor fields hold: `pix_ce` and `pix_phase` are 1 on every cycle.
- R6: Within each period, `pix_phase` is 1 for the first ceil(D/2) cycles and 0 for the rest. For odd D, the high part is one cycle longer than the low part.
- R7: `pix_ce` is 1 only on the first cycle of a period, and that cycle is always a high-phase cycle.
- R8: The divisor inputs (`bypass`, `div_hi`, `div_lo`) are sampled only at the edge that starts a period. A change made part-way through a period takes effect at the next period, and the current period finishes at its old length.
- R9: The largest divisor is 2^(LO_W+HI_W)-1, which is 1023 by default. Any programmed value whose D would exceed this runs at D=1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | 1 selects divide-by-one |
| div_lo | input | LO_W | Low part of the programmed divisor value |
| div_hi | input | HI_W | High part of the programmed divisor value |
| pix_ce | output | 1 | One-cycle strobe at the start of each output period |
| pix_phase | output | 1 | Level of the divided clock, high in the first half of the period |

## Verification
Properties check the following on every cycle:
- the counter stays below the latched divisor;
- the latched divisor holds steady everywhere except at a period start;
- a divisor of one wraps the counter on every cycle;
- the strobe only ever falls inside the high phase;
- reset leaves both outputs low.

Some behaviours need the scoreboard scenarios instead. Three of them are the exact period length for a given field pair, the bit order of the two fields and the clamp at the largest divisor. The scenarios also cover the odd/even split of the phase and the deferral of a change made mid-period, since these depend on the field values and on when the stimulus arrives.

// File: rtl/pixclk_div_pkg.sv
// Package pixclk_div_pkg
// Shared helpers for the pixel clock divider.
// Assumes divisor values are plain unsigned integers of at most 31 bits.
package pixclk_div_pkg;

    // Number of high-phase cycles in a period of length d: ceil(d/2).
    function automatic int unsigned high_len(input int unsigned d);
        return (d + 1) / 2;
    endfunction

endpackage

// File: rtl/pixdiv_decode.sv
// Module pixdiv_decode
// Turns the bypass bit and the two divisor fields into an effective divisor.
// Rules: bypass gives 1; otherwise {hi,lo}+2, saturated at 2^(LO_W+HI_W)-1.
// Assumes: purely combinational; the inputs are quasi-static register fields.
module pixdiv_decode #(
    parameter int LO_W = 5,
    parameter int HI_W = 5,
    localparam int DIV_W = LO_W + HI_W
) (
    input  logic             bypass,
    input  logic [LO_W-1:0]  div_lo,
    input  logic [HI_W-1:0]  div_hi,
    output logic [DIV_W-1:0] divisor
);
    localparam logic [DIV_W:0] DIV_MAX = {1'b0, {DIV_W{1'b1}}};

    logic [DIV_W-1:0] prog;
    logic [DIV_W:0]   sum;

    // Join the fields (low field in the LSBs) and add the fixed offset of two.
    always_comb begin
        prog = {div_hi, div_lo};
        sum  = {1'b0, prog} + (DIV_W+1)'(2);
    end

    // Select divide-by-one, the saturated maximum, or the offset sum.
    always_comb begin
        if (bypass)
            divisor = DIV_W'(1);
        else if (sum > DIV_MAX)
            divisor = DIV_MAX[DIV_W-1:0];
        else
            divisor = sum[DIV_W-1:0];
    end

endmodule

// File: rtl/pixdiv_counter.sv
// Module pixdiv_counter
// Counts reference cycles within one output period and latches the requested
// divisor only at a period boundary (or on the first cycle after reset).
// Exposes the next-state count and divisor so that the output stage can
// register its outputs in step with the counter.
// Assumes: req_div is never 0; synchronous active-low reset.
module pixdiv_counter #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] req_div,
    output logic [DIV_W-1:0] nxt_cnt,
    output logic [DIV_W-1:0] nxt_div
);
    logic             act_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             at_end;

    // The last cycle of the current period, or the idle state right after reset.
    always_comb at_end = !act_q || (cnt_q == (div_q - DIV_W'(1)));

    // Next state: at a boundary restart from zero and take the new divisor.
    always_comb begin
        if (at_end) begin
            nxt_cnt = '0;
            nxt_div = req_div;
        end else begin
            nxt_cnt = cnt_q + DIV_W'(1);
            nxt_div = div_q;
        end
    end

    // State registers, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            div_q <= DIV_W'(1);
        end else begin
            act_q <= 1'b1;
            cnt_q <= nxt_cnt;
            div_q <= nxt_div;
        end
    end

    // The counter never reaches the latched divisor (R3).
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (cnt_q < div_q));

    // Away from a period start, the latched divisor holds its value (R8).
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && cnt_q != '0) |-> $stable(div_q));

    // A divisor of one restarts the period on every cycle (R5).
    p_bypass_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && div_q == DIV_W'(1)) |=> (cnt_q == '0));

endmodule

// File: rtl/pixdiv_shaper.sv
// Module pixdiv_shaper
// Registers the strobe and phase outputs from the counter's next state, so
// the outputs are glitch-free flops aligned with the counter.
// Assumes: nxt_div >= 1 and nxt_cnt < nxt_div.
module pixdiv_shaper #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] nxt_cnt,
    input  logic [DIV_W-1:0] nxt_div,
    output logic             pix_ce,
    output logic             pix_phase
);
    logic [DIV_W:0] hi_len;

    // Length of the high phase: ceil(divisor/2).
    always_comb hi_len = ({1'b0, nxt_div} + (DIV_W+1)'(1)) >> 1;

    // Output flops: strobe at count zero, phase high in the first part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_ce    <= 1'b0;
            pix_phase <= 1'b0;
        end else begin
            pix_ce    <= (nxt_cnt == '0);
            pix_phase <= ({1'b0, nxt_cnt} < hi_len);
        end
    end

    // Reset leaves both outputs low (R1).
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!pix_ce && !pix_phase));

    // The strobe always falls inside the high phase (R7).
    p_ce_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |-> pix_phase);

endmodule

// File: rtl/pixclk_div.sv
// Module pixclk_div
// Pixel clock divider with bypass: derives a clock-enable strobe and a phase
// level at reference/D, where D = {div_hi,div_lo}+2 or 1 when bypassed.
// Assumes: runs entirely on the reference clock; synchronous active-low reset.
module pixclk_div #(
    parameter int LO_W = 5,
    parameter int HI_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bypass,
    input  logic [LO_W-1:0] div_lo,
    input  logic [HI_W-1:0] div_hi,
    output logic            pix_ce,
    output logic            pix_phase
);
    localparam int DIV_W = LO_W + HI_W;

    logic [DIV_W-1:0] req_div;
    logic [DIV_W-1:0] nxt_cnt;
    logic [DIV_W-1:0] nxt_div;

    pixdiv_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
        .bypass  (bypass),
        .div_lo  (div_lo),
        .div_hi  (div_hi),
        .divisor (req_div)
    );

    pixdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_div (req_div),
        .nxt_cnt (nxt_cnt),
        .nxt_div (nxt_div)
    );

    pixdiv_shaper #(.DIV_W(DIV_W)) u_shp (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_cnt   (nxt_cnt),
        .nxt_div   (nxt_div),
        .pix_ce    (pix_ce),
        .pix_phase (pix_phase)
    );

endmodule

// File: tb/sim_pixclk_div.sv
// Scoreboard bench for pixclk_div: the driver computes the expected outputs
// for each cycle from the requirements and queues them; a monitor pops them
// after the matching edge and compares.
module sim_pixclk_div;
    import pixclk_div_pkg::*;

    localparam int LO_W = 5;
    localparam int HI_W = 5;
    localparam int DMAX = (1 << (LO_W + HI_W)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bypass = 1'b0;
    logic [LO_W-1:0] div_lo = '0;
    logic [HI_W-1:0] div_hi = '0;
    logic            pix_ce;
    logic            pix_phase;

    pixclk_div #(.LO_W(LO_W), .HI_W(HI_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .div_lo(div_lo), .div_hi(div_hi),
        .pix_ce(pix_ce), .pix_phase(pix_phase)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        int       stamp;
        bit       ce;
        bit       ph;
        bit [23:0] tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit [23:0] cur_tag = "R1";

    // Reference model state (derived from the requirements).
    bit m_act = 0;
    int m_cnt = 0;
    int m_div = 1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff_div();
        int s;
        if (bypass) return 1;
        s = int'({div_hi, div_lo}) + 2;       // R4: low field in LSBs, R3: +2
        return (s > DMAX) ? DMAX : s;          // R9: saturate
    endfunction

    // Driver: model the next edge with current inputs, queue expectation, step.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            if (!rst_n) begin
                m_act = 0; m_cnt = 0;
            end else if (!m_act || m_cnt == m_div - 1) begin
                m_act = 1; m_cnt = 0; m_div = eff_div();   // R2, R8
            end else begin
                m_cnt = m_cnt + 1;
            end
            e.stamp = cyc + 1;
            e.ce    = m_act && (m_cnt == 0);                          // R7
            e.ph    = m_act && (m_cnt < int'(high_len(m_div)));       // R6
            e.tag   = cur_tag;
            q.push_back(e);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Monitor: compare each queued expectation once its edge has passed.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (pix_ce !== e.ce || pix_phase !== e.ph) begin
                n_fail++;
                $display("FAIL %s cycle %0d: ce/phase actual %b%b expected %b%b",
                         e.tag, cyc, pix_ce, pix_phase, e.ce, e.ph);
            end
        end
    end

    task automatic set_div(input bit b, input int hi, input int lo);
        bypass = b;
        div_hi = HI_W'(hi);
        div_lo = LO_W'(lo);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1"; rst_n = 0; set_div(0, 0, 0);
        tick(3);
        // R2 then R3: smallest divisor, D=2
        cur_tag = "R2"; rst_n = 1;
        tick(1);
        cur_tag = "R3";
        tick(9);
        // R6: odd divisor D=5 (value 3), change taken at boundary
        cur_tag = "R6"; set_div(0, 0, 3);
        tick(22);
        // R6: even divisor D=8 (value 6)
        set_div(0, 0, 6);
        tick(26);
        // R4: high field weight, hi=1 lo=0 -> D=34
        cur_tag = "R4"; set_div(0, 1, 0);
        tick(80);
        // R5: bypass ignores fields
        cur_tag = "R5"; set_div(1, 17, 9);
        tick(12);
        set_div(1, 3, 30);
        tick(6);
        // R8: D=7, then change to D=3 part-way through a period
        cur_tag = "R8"; set_div(0, 0, 5);
        tick(10);
        set_div(0, 0, 1);
        tick(12);
        set_div(0, 0, 5);
        tick(3);
        set_div(0, 2, 4);
        tick(90);
        // R9: saturate at the largest divisor
        cur_tag = "R9"; set_div(0, 31, 31);
        tick(2100);
        set_div(0, 31, 29);                 // value 1021 -> exactly 1023
        tick(1100);
        // R1/R2: reset in the middle of a period, then restart
        cur_tag = "R1"; set_div(0, 0, 2); rst_n = 0;
        tick(2);
        cur_tag = "R2"; rst_n = 1;
        tick(12);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule